// File: doc/BRIEF.md
# Byte-Masked One-Time-Programmable Page Controller

This block fronts a store of 128-bit pages with a small register file on a synchronous request/response port. Software places a 128-bit value in four 32-bit staging words, then writes a command register that names a page and asks for a program (staging to page), a fetch (page to staging), or both. The copy is filtered byte by byte through a 16-bit byte-enable register: a byte moves only when its enable bit is set, and a byte whose enable bit is clear keeps its old value at the destination.

Each register insists on its own access size. The command, enable and status registers take only 2-byte accesses. The timing word and the staging words take only 4-byte accesses. A request of any size other than 2 or 4 bytes is refused before the address is looked at. The response comes back one cycle after the request and carries a result code. A completed command raises a done flag in a write-one-to-clear status register. The same flag is driven on a level output.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset, command reads 0x0000, byte-enable reads 0xFFFF, status reads 0x0000, timing reads 0x00001485, every staging word reads 0, and done_o is 0.
- R2: Every request cycle with req_valid high is answered one cycle later with rsp_valid high. rsp_rdata is 0 except on a read whose code is 0 (OK).
- R3: A request whose size is neither 2 nor 4 returns code 1 (SIZE), even at an unmapped offset or a register of the other width, and changes no state.
- R4: A 4-byte access to command (0x00), byte-enable (0x04) or status (0x08), or a 2-byte access to timing (0x0C) or staging words 0..3 (0x80, 0x84, 0x88, 0x8C), returns code 2 (WIDTH) and changes no state.
- R5: A 2- or 4-byte access to any other offset returns code 3 (UNMAPPED) with rsp_rdata 0 and changes no state.
- R6: A command write stores only the bits under mask 0x39FF, and a read returns the stored value. Bits [8:0] select one of 512 pages.
- R7: With command bit 12 set, the staging words are copied into the selected page. Word 0 forms page bytes 0..3 and word 3 forms bytes 12..15 (little-endian within each word).
- R8: With command bit 11 set, the selected page is copied into the staging words with the same byte layout. Other pages are unaffected.
- R9: With both bits 12 and 11 set, the program happens first and the fetch then reads the updated page.
- R10: In both directions, byte i (0..15) is copied only when byte-enable bit i is 1. Otherwise the destination byte is unchanged.
- R11: Every accepted command write, with or without command bits, sets status bit 0 and done_o one cycle after the cycle that returns its response. The transfer is visible to requests issued from that cycle on.
- R12: Status bits are write-one-to-clear: a write clears exactly the bits written as 1, and writing 0 leaves done set.
- R13: Timing is a plain 32-bit read/write register, and its value does not change any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data; 2-byte accesses use bits [15:0] |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_code | output | 2 | 0 OK, 1 SIZE, 2 WIDTH, 3 UNMAPPED |
| rsp_rdata | output | 32 | Read data, zero-extended for 2-byte registers |
| done_o | output | 1 | Level copy of status done bit |

## Verification
A request presented before edge E is answered just after E, so the bench drives on a falling edge and reads rsp_code and rsp_rdata on the next falling edge. A command write is accepted at E, but its page transfer and the done flag land at E+1. The bench checks that done_o is still low at the response sample and high one falling edge later, and it waits that extra cycle before reading staging words back. Expected page contents come from a bench-side byte-merge model of the store. This model is updated only from the byte-enable and staging values the bench itself wrote.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int OFFS_W = 8;

  localparam logic [OFFS_W-1:0] OFF_CMD   = 8'h00;
  localparam logic [OFFS_W-1:0] OFF_LANE  = 8'h04;
  localparam logic [OFFS_W-1:0] OFF_FLAG  = 8'h08;
  localparam logic [OFFS_W-1:0] OFF_TIME  = 8'h0C;
  localparam logic [OFFS_W-1:0] OFF_STAGE = 8'h80;

  localparam logic [15:0] CMD_KEEP   = 16'h39FF;
  localparam logic [15:0] LANE_RESET = 16'hFFFF;
  localparam logic [31:0] TIME_RESET = 32'h0000_1485;

  localparam int PROG_BIT  = 12;
  localparam int FETCH_BIT = 11;
  localparam int DONE_BIT  = 0;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_SIZE  = 2'd1,
    RSP_WIDTH = 2'd2,
    RSP_NOMAP = 2'd3
  } rsp_e;

  typedef struct packed {
    logic cmd;
    logic lane;
    logic flag;
    logic timing;
  } sel_t;
endpackage

// File: rtl/otp_bus_decode.sv
module otp_bus_decode
  import otp_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic              req_valid,
  input  logic [OFFS_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  output rsp_e              code,
  output sel_t              sel,
  output logic [WORDS-1:0]  stage_sel
);
  logic narrow_hit;
  logic wide_hit;
  logic [WORDS-1:0] stage_hit;

  always_comb begin
    for (int w = 0; w < WORDS; w++) begin
      stage_hit[w] = (req_addr == OFF_STAGE + OFFS_W'(4 * w));
    end
    narrow_hit = (req_addr == OFF_CMD) || (req_addr == OFF_LANE) ||
                 (req_addr == OFF_FLAG);
    wide_hit   = (req_addr == OFF_TIME) || (|stage_hit);
  end

  always_comb begin
    code      = RSP_OK;
    sel       = '0;
    stage_sel = '0;
    if (req_size != 3'd2 && req_size != 3'd4) begin
      code = RSP_SIZE;
    end else if (!narrow_hit && !wide_hit) begin
      code = RSP_NOMAP;
    end else if ((narrow_hit && req_size != 3'd2) ||
                 (wide_hit && req_size != 3'd4)) begin
      code = RSP_WIDTH;
    end else if (req_valid) begin
      sel.cmd    = (req_addr == OFF_CMD);
      sel.lane   = (req_addr == OFF_LANE);
      sel.flag   = (req_addr == OFF_FLAG);
      sel.timing = (req_addr == OFF_TIME);
      stage_sel  = stage_hit;
    end
  end
endmodule

// File: rtl/otp_xfer_merge.sv
module otp_xfer_merge #(
  parameter int LANES = 16,
  localparam int BITS = LANES * 8
) (
  input  logic [LANES-1:0] lane_en,
  input  logic             do_prog,
  input  logic             do_fetch,
  input  logic [BITS-1:0]  stage_cur,
  input  logic [BITS-1:0]  page_cur,
  output logic [BITS-1:0]  page_new,
  output logic [BITS-1:0]  stage_new
);
  for (genvar l = 0; l < LANES; l++) begin : g_byte
    logic [7:0] page_after;
    assign page_after = (do_prog && lane_en[l]) ? stage_cur[l*8 +: 8]
                                                : page_cur[l*8 +: 8];
    assign page_new[l*8 +: 8]  = page_after;
    assign stage_new[l*8 +: 8] = (do_fetch && lane_en[l]) ? page_after
                                                          : stage_cur[l*8 +: 8];
  end
endmodule

// File: rtl/otp_page_store.sv
module otp_page_store #(
  parameter int PAGES = 512,
  parameter int LANES = 16,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int BITS   = LANES * 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] page,
  input  logic [LANES-1:0]  lane_en,
  input  logic [BITS-1:0]   wr_data,
  output logic [BITS-1:0]   rd_data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] cells [PAGES];
    always_ff @(posedge clk) begin
      if (wr_en && lane_en[l]) begin
        cells[page] <= wr_data[l*8 +: 8];
      end
    end
    assign rd_data[l*8 +: 8] = cells[page];
  end
endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_pkg::*;
#(
  parameter int PAGES = 512,
  parameter int LANES = 16,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int WORDS  = LANES / 4,
  localparam int BITS   = LANES * 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [1:0]  rsp_code,
  output logic [31:0] rsp_rdata,
  output logic        done_o
);
  rsp_e             code;
  sel_t             sel;
  logic [WORDS-1:0] stage_sel;
  logic             wr_ok;

  logic [15:0] cmd_q, cmd_d;
  logic [15:0] lane_q, lane_d;
  logic [15:0] flag_q, flag_d;
  logic [31:0] time_q, time_d;
  logic [31:0] stage_q [WORDS];
  logic [31:0] stage_d [WORDS];
  logic        pend_q, pend_d;
  logic        rv_q, rv_d;
  logic [1:0]  rc_q, rc_d;
  logic [31:0] rd_q, rd_d;
  logic [31:0] rd_val;

  logic [BITS-1:0] stage_flat, page_cur, page_new, stage_new;
  logic            do_prog, do_fetch;

  otp_bus_decode #(.WORDS(WORDS)) u_decode (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .code      (code),
    .sel       (sel),
    .stage_sel (stage_sel)
  );

  assign wr_ok    = req_valid && req_write && (code == RSP_OK);
  assign do_prog  = pend_q && cmd_q[PROG_BIT];
  assign do_fetch = pend_q && cmd_q[FETCH_BIT];

  for (genvar w = 0; w < WORDS; w++) begin : g_flat
    assign stage_flat[w*32 +: 32] = stage_q[w];
  end

  otp_xfer_merge #(.LANES(LANES)) u_merge (
    .lane_en   (lane_q[LANES-1:0]),
    .do_prog   (do_prog),
    .do_fetch  (do_fetch),
    .stage_cur (stage_flat),
    .page_cur  (page_cur),
    .page_new  (page_new),
    .stage_new (stage_new)
  );

  otp_page_store #(.PAGES(PAGES), .LANES(LANES)) u_store (
    .clk     (clk),
    .wr_en   (do_prog),
    .page    (cmd_q[PAGE_W-1:0]),
    .lane_en (lane_q[LANES-1:0]),
    .wr_data (page_new),
    .rd_data (page_cur)
  );

  // next-state: register file
  always_comb begin
    cmd_d  = cmd_q;
    lane_d = lane_q;
    time_d = time_q;
    flag_d = flag_q;
    pend_d = 1'b0;
    if (wr_ok && sel.cmd) begin
      cmd_d  = req_wdata[15:0] & CMD_KEEP;
      pend_d = 1'b1;
    end
    if (wr_ok && sel.lane)   lane_d = req_wdata[15:0];
    if (wr_ok && sel.timing) time_d = req_wdata;
    if (wr_ok && sel.flag)   flag_d = flag_q & ~req_wdata[15:0];
    if (pend_q)              flag_d[DONE_BIT] = 1'b1;
    for (int w = 0; w < WORDS; w++) begin
      stage_d[w] = stage_new[w*32 +: 32];
      if (wr_ok && stage_sel[w]) stage_d[w] = req_wdata;
    end
  end

  // next-state: response
  always_comb begin
    rd_val = '0;
    if (sel.cmd)    rd_val = {16'h0, cmd_q};
    if (sel.lane)   rd_val = {16'h0, lane_q};
    if (sel.flag)   rd_val = {16'h0, flag_q};
    if (sel.timing) rd_val = time_q;
    for (int w = 0; w < WORDS; w++) begin
      if (stage_sel[w]) rd_val = stage_q[w];
    end
    rv_d = req_valid;
    rc_d = req_valid ? code : RSP_OK;
    rd_d = (req_valid && !req_write && code == RSP_OK) ? rd_val : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      lane_q <= LANE_RESET;
      flag_q <= '0;
      time_q <= TIME_RESET;
      pend_q <= 1'b0;
      rv_q   <= 1'b0;
      rc_q   <= RSP_OK;
      rd_q   <= '0;
      for (int w = 0; w < WORDS; w++) stage_q[w] <= '0;
    end else begin
      cmd_q  <= cmd_d;
      lane_q <= lane_d;
      flag_q <= flag_d;
      time_q <= time_d;
      pend_q <= pend_d;
      rv_q   <= rv_d;
      rc_q   <= rc_d;
      rd_q   <= rd_d;
      for (int w = 0; w < WORDS; w++) stage_q[w] <= stage_d[w];
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_code  = rc_q;
  assign rsp_rdata = rd_q;
  assign done_o    = flag_q[DONE_BIT];
endmodule

// File: rtl/otp_page_ctrl_chk.sv
module otp_page_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [7:0]  req_addr,
  input logic [2:0]  req_size,
  input logic        rsp_valid,
  input logic [1:0]  rsp_code,
  input logic [31:0] rsp_rdata,
  input logic        done_o
);
  logic size_ok, mapped;
  assign size_ok = (req_size == 3'd2) || (req_size == 3'd4);
  assign mapped  = req_addr inside {8'h00, 8'h04, 8'h08, 8'h0C,
                                    8'h80, 8'h84, 8'h88, 8'h8C};

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  resp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R2
  err_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_rdata == 32'h0));

  // R3
  size_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !size_ok) |=> (rsp_code == 2'd1));

  // R5
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && size_ok && !mapped) |=> (rsp_code == 2'd3));

  // R11
  done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h00 && req_size == 3'd2)
      |=> ##1 done_o);
endmodule

bind otp_page_ctrl otp_page_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_code  (rsp_code),
  .rsp_rdata (rsp_rdata),
  .done_o    (done_o)
);

// File: tb/test_otp_page_ctrl.sv
module test_otp_page_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_rdata;
  logic        done_o;

  int tests_run = 0;
  int tests_failed = 0;

  logic [127:0] model_pg [512];
  logic [127:0] model_stage;
  logic [15:0]  model_en;

  always #4 clk = ~clk;

  otp_page_ctrl i_otp_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
    .done_o(done_o)
  );

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [2:0] sz,
                     input logic [31:0] wd, output logic [1:0] code,
                     output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    code = rsp_code; rd = rsp_rdata;
    if (rsp_valid !== 1'b1) check("R2 rsp_valid", {31'h0, rsp_valid}, 32'h1);
  endtask

  function automatic logic [127:0] merge(input logic [127:0] old,
                                         input logic [127:0] nw,
                                         input logic [15:0] en);
    logic [127:0] r = old;
    for (int i = 0; i < 16; i++) if (en[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic wr16(input logic [7:0] a, input logic [15:0] v);
    logic [1:0] c; logic [31:0] d;
    bus(1'b1, a, 3'd2, {16'h0, v}, c, d);
    if (a == 8'h04) model_en = v;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] v);
    logic [1:0] c; logic [31:0] d;
    bus(1'b1, a, 3'd4, v, c, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sz,
                    output logic [31:0] v);
    logic [1:0] c;
    bus(1'b0, a, sz, 32'h0, c, v);
  endtask

  task automatic load_stage(input logic [127:0] v);
    for (int w = 0; w < 4; w++) wr32(8'h80 + 8'(4 * w), v[w*32 +: 32]);
    model_stage = v;
  endtask

  task automatic check_stage(input string req, input logic [127:0] exp);
    logic [31:0] v;
    for (int w = 0; w < 4; w++) begin
      rd(8'h80 + 8'(4 * w), 3'd4, v);
      check(req, v, exp[w*32 +: 32]);
    end
  endtask

  // issue a command and keep the model in step; waits out the transfer cycle
  task automatic command(input logic [15:0] v);
    logic [8:0] pg = v[8:0];
    wr16(8'h00, v);
    @(negedge clk);
    if (v[12]) model_pg[pg] = merge(model_pg[pg], model_stage, model_en);
    if (v[11]) model_stage = merge(model_stage, model_pg[pg], model_en);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, 3'd2, v); check("R1 cmd", v, 32'h0);
    rd(8'h04, 3'd2, v); check("R1 enable", v, 32'hFFFF);
    rd(8'h08, 3'd2, v); check("R1 status", v, 32'h0);
    rd(8'h0C, 3'd4, v); check("R1 timing", v, 32'h1485);
    check_stage("R1 stage", 128'h0);
    check("R1 done_o", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_size;
    logic [1:0] c; logic [31:0] v;
    bus(1'b0, 8'h00, 3'd1, 32'h0, c, v); check("R3 size1 cmd", {30'h0, c}, 32'h1);
    bus(1'b1, 8'h40, 3'd3, 32'h0, c, v); check("R3 size3 unmapped", {30'h0, c}, 32'h1);
    bus(1'b1, 8'h04, 3'd1, 32'h0, c, v); check("R3 size1 code", {30'h0, c}, 32'h1);
    rd(8'h04, 3'd2, v); check("R3 enable untouched", v, 32'hFFFF);
  endtask

  task automatic t_width;
    logic [1:0] c; logic [31:0] v;
    bus(1'b1, 8'h04, 3'd4, 32'h0, c, v); check("R4 enable 4B", {30'h0, c}, 32'h2);
    rd(8'h04, 3'd2, v); check("R4 enable kept", v, 32'hFFFF);
    bus(1'b1, 8'h0C, 3'd2, 32'h7, c, v); check("R4 timing 2B", {30'h0, c}, 32'h2);
    rd(8'h0C, 3'd4, v); check("R4 timing kept", v, 32'h1485);
    bus(1'b1, 8'h00, 3'd4, 32'h1001, c, v); check("R4 cmd 4B", {30'h0, c}, 32'h2);
    @(negedge clk);
    check("R4 no done", {31'h0, done_o}, 32'h0);
    bus(1'b0, 8'h84, 3'd2, 32'h0, c, v); check("R4 stage 2B rdata", v, 32'h0);
  endtask

  task automatic t_nomap;
    logic [1:0] c; logic [31:0] v;
    bus(1'b0, 8'h10, 3'd4, 32'h0, c, v);
    check("R5 code", {30'h0, c}, 32'h3); check("R5 rdata", v, 32'h0);
    bus(1'b1, 8'h90, 3'd4, 32'h1, c, v); check("R5 write code", {30'h0, c}, 32'h3);
  endtask

  task automatic t_cmd_mask;
    logic [31:0] v;
    command(16'hC6FF);
    rd(8'h00, 3'd2, v); check("R6 masked", v, 32'h00FF);
  endtask

  task automatic t_done;
    logic [31:0] v;
    wr16(8'h08, 16'h0000);
    rd(8'h08, 3'd2, v); check("R12 write 0 keeps", v, 32'h1);
    wr16(8'h08, 16'hFFFF);
    rd(8'h08, 3'd2, v); check("R12 cleared", v, 32'h0);
    check("R12 done_o low", {31'h0, done_o}, 32'h0);
    wr16(8'h00, 16'h0003);
    check("R11 not yet", {31'h0, done_o}, 32'h0);
    @(negedge clk);
    check("R11 done_o", {31'h0, done_o}, 32'h1);
    rd(8'h08, 3'd2, v); check("R11 status bit0", v, 32'h1);
    wr16(8'h08, 16'h0001);
  endtask

  task automatic t_prog_fetch;
    load_stage(128'h0F0E0D0C_0B0A0908_07060504_03020100);
    command(16'h1005);
    load_stage(128'h11111111_22222222_33333333_44444444);
    command(16'h1006);
    load_stage(128'h0);
    command(16'h0805);
    check_stage("R7 R8 page5", model_pg[5]);
    command(16'h0806);
    check_stage("R8 page6", model_pg[6]);
  endtask

  task automatic t_lanes;
    wr16(8'h04, 16'h0F0F);
    load_stage(128'hAAAAAAAA_BBBBBBBB_CCCCCCCC_DDDDDDDD);
    command(16'h1005);
    wr16(8'h04, 16'hFFFF);
    load_stage(128'h0);
    command(16'h0805);
    check_stage("R10 prog mask", model_pg[5]);
    wr16(8'h04, 16'h00F0);
    load_stage(128'h99999999_88888888_77777777_66666666);
    command(16'h0806);
    check_stage("R10 fetch mask", model_stage);
  endtask

  task automatic t_both;
    wr16(8'h04, 16'hFFFF);
    load_stage(128'h01234567_89ABCDEF_FEDCBA98_76543210);
    command(16'h1807);
    check_stage("R9 stage after both", model_stage);
    wr16(8'h04, 16'h00FF);
    load_stage(128'h55555555_66666666_77777777_88888888);
    command(16'h1807);
    check_stage("R9 partial both", model_stage);
    wr16(8'h04, 16'hFFFF);
    load_stage(128'h0);
    command(16'h0807);
    check_stage("R9 page7", model_pg[7]);
  endtask

  task automatic t_timing;
    logic [31:0] v;
    wr32(8'h0C, 32'hDEADBEEF);
    rd(8'h0C, 3'd4, v); check("R13 timing rw", v, 32'hDEADBEEF);
    command(16'h0805);
    check_stage("R13 fetch unaffected", model_pg[5]);
    rd(8'h0C, 3'd4, v); check("R13 timing kept", v, 32'hDEADBEEF);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    model_en = 16'hFFFF;
    model_stage = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_size;
    t_width;
    t_nomap;
    t_cmd_mask;
    t_done;
    t_prog_fetch;
    t_lanes;
    t_both;
    t_timing;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule